// File: doc/BRIEF.md
# Video Memory Host Port With Read-Ahead

This block is the host-side path into the video memory of a display controller. A host processor sends it single-byte requests on one request channel. A request is a control byte, a data write, or a data read. Two control bytes in a row load a memory pointer and say whether the host intends to read or write. Data traffic then passes through a one-byte read-ahead buffer. A read hands back the byte that was already fetched and asks for the next one. A write places its byte in the buffer and asks for the buffer to be stored.

The block does not touch memory when the request arrives. It holds at most one pending transfer, and it runs that transfer only in an access slot that the display timing grants. The slot must also fall at or after a minimum column, which the block sets a fixed latency after each host request. The transfer uses the pointer, which then moves on by one. In the two widest bitmap modes, the memory address is the pointer rotated right by one bit, so the two interleaved banks look like one linear space. The address is finally masked to the size of the installed memory.

The request channel uses valid/ready. `req_ready` stays low while a transfer is pending, so the host is back-pressured and no request is lost. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Nothing else in the block stalls.

Top module: `vram_access_port`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_en` is 0 and `rd_data` is 0. The next control byte is treated as the first byte of a pair.
- R2: Request op 0 is a control byte. Control bytes alternate between first and second. The first byte is stored as pointer bits 7:0 and has no memory effect. The second byte sets pointer bits 13:8 from its bits 5:0 and clears every pointer bit above 13.
- R3: Bit 6 of the second control byte chooses the direction. A 1 sets up writing and queues nothing. A 0 queues a read of the new pointer into the buffer.
- R4: Request op 1 is a data write. It loads `req_data` into the buffer, queues a store of the buffer at the pointer, and makes the next control byte a first byte.
- R5: Request op 2 is a data read. During the request, `rd_data` shows the buffer. The request queues a read at the pointer and makes the next control byte a first byte.
- R6: A queued transfer runs, with `mem_en` high for one cycle, only in a cycle where `slot_valid` is high and `line_col` is at least the minimum column. Each accepted request sets the minimum column to the request's `line_col` plus LAT. A cycle with `line_col` 0 and no accepted request clears it to 0.
- R7: Each executed transfer advances the pointer by one, wrapping at ADDR_W bits.
- R8: With `wide_mode` high, the address is the pointer rotated right by one, so that bit 0 lands in bit ADDR_W-1.
- R9: `mem_addr` is the (possibly rotated) pointer ANDed with 2^MEM_AW-1. All of its bits from MEM_AW upward are zero.
- R10: `req_ready` is low from the acceptance of a queueing request until its transfer runs, and high in the cycle after. An executed read places `mem_rdata` in the buffer.
- R11: Request op 3 is reserved. It is accepted, queues nothing and changes neither the pointer nor the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid; low while a transfer is pending |
| req_op | input | 2 | 0 control byte, 1 data write, 2 data read, 3 reserved |
| req_data | input | 8 | Control or write byte |
| rd_data | output | 8 | Read-ahead buffer contents, the result of a data read |
| wide_mode | input | 1 | High in the two widest bitmap modes: bank-interleave rotation |
| line_col | input | COL_W | Current column of the display line |
| slot_valid | input | 1 | Display timing grants an external access slot this cycle |
| mem_en | output | 1 | Memory transfer this cycle |
| mem_we | output | 1 | Transfer is a store (valid with mem_en) |
| mem_addr | output | ADDR_W | Masked, possibly rotated memory address |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Memory read data, same-cycle |

## Verification
The bench builds the port with ADDR_W=15, MEM_AW=14, COL_W=8 and LAT=3. With these values the pointer can cross 0x4000, so a single write sequence shows the mask wrap. The rotated bit 0 lands in bit 14, which the mask then removes, so wide mode shows up as a clean halving of the address. The 8-bit column lets a request near the end of a line push the minimum column past any column the line reaches. Only the clear at column 0 can then release the transfer. The bench also sweeps pointer values over both modes and checks each address against an arithmetic model of the rotation and mask.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_t;

  localparam logic [1:0] OP_CTRL  = 2'd0;
  localparam logic [1:0] OP_WDATA = 2'd1;
  localparam logic [1:0] OP_RDATA = 2'd2;
endpackage

// File: rtl/vrp_slot_gate.sv
// Tracks the earliest column at which a queued transfer may use a slot.
module vrp_slot_gate #(
  parameter int COL_W = 11,
  parameter int LAT   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] col,
  input  logic             touch,
  input  logic             slot_valid,
  input  logic             pending,
  output logic             fire
);
  localparam int MW = COL_W + 1;   // room for a column plus latency past line end

  logic [MW-1:0] min_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           min_q <= '0;
    else if (touch)       min_q <= {1'b0, col} + MW'(LAT);
    else if (col == '0)   min_q <= '0;
  end

  assign fire = pending && slot_valid && ({1'b0, col} >= min_q);
endmodule

// File: rtl/vrp_addr_map.sv
// Bank-interleave rotation followed by masking to the installed size.
module vrp_addr_map #(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 17
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'((64'd1 << MEM_AW) - 64'd1);

  logic [ADDR_W-1:0] rot;

  always_comb begin
    rot  = wide ? {ptr[0], ptr[ADDR_W-1:1]} : ptr;
    addr = rot & MASK;
  end
endmodule

// File: rtl/vram_access_port.sv
module vram_access_port #(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 17,
  parameter int COL_W  = 11,
  parameter int LAT    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [7:0]        req_data,
  output logic [7:0]        rd_data,
  input  logic              wide_mode,
  input  logic [COL_W-1:0]  line_col,
  input  logic              slot_valid,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  import vrp_pkg::*;

  logic              phase_q;   // 1: next control byte is the second
  logic [7:0]        low_q;
  logic [7:0]        buf_q;
  logic [ADDR_W-1:0] ptr_q;
  acc_t              acc_q;
  logic              hs;
  logic              fire;

  assign req_ready = (acc_q == ACC_IDLE);
  assign hs        = req_valid && req_ready;

  vrp_slot_gate #(.COL_W(COL_W), .LAT(LAT)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .col        (line_col),
    .touch      (hs),
    .slot_valid (slot_valid),
    .pending    (acc_q != ACC_IDLE),
    .fire       (fire)
  );

  vrp_addr_map #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_map (
    .ptr  (ptr_q),
    .wide (wide_mode),
    .addr (mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      low_q   <= '0;
      buf_q   <= '0;
      ptr_q   <= '0;
      acc_q   <= ACC_IDLE;
    end else if (hs) begin
      unique case (req_op)
        OP_CTRL: begin
          if (!phase_q) begin
            low_q   <= req_data;
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            ptr_q   <= ADDR_W'({req_data[5:0], low_q});
            acc_q   <= req_data[6] ? ACC_IDLE : ACC_READ;
          end
        end
        OP_WDATA: begin
          buf_q   <= req_data;
          acc_q   <= ACC_WRITE;
          phase_q <= 1'b0;
        end
        OP_RDATA: begin
          acc_q   <= ACC_READ;
          phase_q <= 1'b0;
        end
        default: ;
      endcase
    end else if (fire) begin
      if (acc_q == ACC_READ) buf_q <= mem_rdata;
      ptr_q <= ptr_q + ADDR_W'(1);
      acc_q <= ACC_IDLE;
    end
  end

  assign mem_en    = fire;
  assign mem_we    = fire && (acc_q == ACC_WRITE);
  assign mem_wdata = buf_q;
  assign rd_data   = buf_q;
endmodule

// File: rtl/vrp_checker.sv
module vrp_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [7:0]        req_data,
  input logic [7:0]        rd_data,
  input logic              mem_en,
  input logic              mem_we,
  input logic [7:0]        mem_rdata,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              phase_q
);
  logic hs;
  assign hs = req_valid && req_ready;

  a_r10_no_exec_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> !mem_en);

  a_r7_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> ptr_q == $past(ptr_q) + ADDR_W'(1));

  a_r10_read_fills_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> rd_data == $past(mem_rdata));

  a_r10_ready_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> req_ready);

  a_r2_first_byte_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_op == 2'd0 && !phase_q) |=> phase_q);

  a_r4_data_queues: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (req_op == 2'd1 || req_op == 2'd2)) |=> (!req_ready && !phase_q));

  a_r4_write_loads_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_op == 2'd1) |=> rd_data == $past(req_data));
endmodule

bind vram_access_port vrp_checker #(.ADDR_W(ADDR_W)) u_vrp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_data  (req_data),
  .rd_data   (rd_data),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_rdata (mem_rdata),
  .ptr_q     (ptr_q),
  .phase_q   (phase_q)
);

// File: tb/test_vram_access_port.sv
`timescale 1ns/1ps
module test_vram_access_port;
  localparam int AW = 15;
  localparam int MW = 14;
  localparam int CW = 8;
  localparam int LT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [7:0]    req_data = 8'd0;
  logic [7:0]    rd_data;
  logic          wide_mode = 1'b0;
  logic [CW-1:0] line_col = 8'd20;
  logic          slot_valid = 1'b0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;

  int checks = 0;
  int fails  = 0;
  int base_col = 20;
  logic [7:0] cap_rd;
  logic s_en, s_we;
  logic [AW-1:0] s_addr;
  logic [7:0] s_wd;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ 8'h3C;

  vram_access_port #(.ADDR_W(AW), .MEM_AW(MW), .COL_W(CW), .LAT(LT)) i_vram_access_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .rd_data(rd_data), .wide_mode(wide_mode),
    .line_col(line_col), .slot_valid(slot_valid), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [AW-1:0] amap(input logic [AW-1:0] p, input logic w);
    logic [AW-1:0] r;
    r = w ? {p[0], p[AW-1:1]} : p;
    return r & AW'(15'h3FFF);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    cap_rd = rd_data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic slot(input int col);
    @(negedge clk);
    line_col = CW'(col); slot_valid = 1'b1;
    #1;
    s_en = mem_en; s_we = mem_we; s_addr = mem_addr; s_wd = mem_wdata;
    @(negedge clk);
    slot_valid = 1'b0; line_col = CW'(base_col);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "ready", req_ready, 1);
    chk("R1", "mem_en", mem_en, 0);
    chk("R1", "rd_data", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;

    // write setup to 0x1234
    send(2'd0, 8'h34);
    send(2'd0, 8'h52);
    #1 chk("R3", "ready after write setup", req_ready, 1);
    slot(30);
    chk("R3", "no access after write setup", s_en, 0);

    // data write, latency gate
    send(2'd1, 8'h5A);
    #1 chk("R10", "ready while pending", req_ready, 0);
    slot(base_col + LT - 1);
    chk("R6", "early slot refused", s_en, 0);
    slot(base_col + LT);
    chk("R6", "slot at minimum column", s_en, 1);
    chk("R4", "we", s_we, 1);
    chk("R4", "addr", s_addr, 15'h1234);
    chk("R4", "wdata", s_wd, 8'h5A);
    #1 chk("R10", "ready after exec", req_ready, 1);

    send(2'd1, 8'h77);
    slot(base_col + LT);
    chk("R7", "incremented addr", s_addr, 15'h1235);

    // read setup to 0x0500
    send(2'd0, 8'h00);
    send(2'd0, 8'h05);
    #1 chk("R3", "read setup queues", req_ready, 0);
    slot(base_col + LT);
    chk("R3", "prefetch en", s_en, 1);
    chk("R3", "prefetch is read", s_we, 0);
    chk("R3", "prefetch addr", s_addr, 15'h0500);
    #1 chk("R10", "buffer filled", rd_data, 8'h00 ^ 8'h3C);

    send(2'd2, 8'h00);
    chk("R5", "read returns buffer", cap_rd, 8'h3C);
    slot(base_col + LT);
    chk("R5", "next read addr", s_addr, 15'h0501);
    #1 chk("R10", "buffer refilled", rd_data, 8'h01 ^ 8'h3C);

    // phase reset by data access
    send(2'd0, 8'h99);
    send(2'd1, 8'h11);
    slot(base_col + LT);
    chk("R2", "first byte leaves pointer", s_addr, 15'h0502);
    send(2'd0, 8'h00);
    send(2'd0, 8'h43);
    send(2'd1, 8'h22);
    slot(base_col + LT);
    chk("R4", "phase reset by data write", s_addr, 15'h0300);

    // reserved op
    send(2'd3, 8'hFF);
    #1 chk("R11", "reserved queues nothing", req_ready, 1);
    chk("R11", "reserved keeps buffer", rd_data, 8'h22);
    slot(base_col + LT);
    chk("R11", "reserved no access", s_en, 0);
    send(2'd1, 8'h33);
    slot(base_col + LT);
    chk("R11", "reserved keeps pointer", s_addr, 15'h0301);

    // mask wrap
    send(2'd0, 8'hFF);
    send(2'd0, 8'h7F);
    send(2'd1, 8'h01);
    slot(base_col + LT);
    chk("R9", "top of memory", s_addr, 15'h3FFF);
    send(2'd1, 8'h02);
    slot(base_col + LT);
    chk("R9", "wrap past size", s_addr, 15'h0000);
    wide_mode = 1'b1;
    send(2'd1, 8'h03);
    slot(base_col + LT);
    chk("R8", "rotated and masked", s_addr, 15'h2000);
    wide_mode = 1'b0;

    // sweep over both modes
    for (int k = 0; k < 40; k++) begin
      logic [7:0] lo, hi;
      logic [AW-1:0] p;
      lo = 8'(k * 37 + 5);
      hi = 8'((k * 11) & 8'h3F);
      p  = AW'({hi[5:0], lo});
      wide_mode = k[0];
      send(2'd0, lo);
      send(2'd0, hi | 8'h40);
      send(2'd1, 8'(k) ^ 8'h55);
      slot(base_col + LT);
      chk(k[0] ? "R8" : "R9", "sweep addr", s_addr, amap(p, k[0]));
      chk("R4", "sweep wdata", s_wd, 8'(k) ^ 8'h55);
      send(2'd1, 8'hA0);
      slot(base_col + LT);
      chk("R7", "sweep next addr", s_addr, amap(p + AW'(1), k[0]));
    end
    wide_mode = 1'b0;

    // minimum column past line end, released by column 0
    base_col = 250;
    @(negedge clk); line_col = 8'd250;
    send(2'd1, 8'h44);
    slot(252);
    chk("R6", "late slot refused", s_en, 0);
    slot(0);
    chk("R6", "column zero slot refused", s_en, 0);
    slot(1);
    chk("R6", "released after line start", s_en, 1);
    base_col = 20;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule